// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the hardware half of a receive descriptor ring. Frames arrive as a byte stream that carries start, end and error flags. The block stores each frame into the data buffer of the current descriptor. Each descriptor holds four things: an ownership flag (`empty`: set while the hardware may fill it), a ring-end flag (`wrap`), a byte count and a small error status field. The descriptor record is written only after the last byte of a frame arrives. Once written, the descriptor belongs to software, and the ring pointer moves on.

Software works through a host port that reads a descriptor and its buffer by index. It gives a descriptor back by pulsing a release strobe. The release marks the descriptor empty, clears its count and status, and loads its wrap flag. The ring can therefore be shortened by setting wrap on an earlier entry. The recorded count includes the 4 trailing CRC bytes, so the payload length is the count minus 4. A frame counts as good only when all six status bits are zero.

Top module: `rx_desc_ring`

## Requirements
- R1: A frame is accepted only when the current descriptor is empty. On the clock edge that samples the end byte, that descriptor's empty flag clears and `frame_done` goes high for one cycle. Its count and status become visible on the host port after that same edge.
- R2: After a frame completes, the ring pointer `ring_pos` moves to 0 if the used descriptor has wrap set or is the last index. Otherwise it moves to the next index.
- R3: The recorded count is the number of bytes received, CRC bytes included. Byte k of the frame can be read back at offset k of that descriptor's buffer.
- R4: Bytes beyond BUF_LEN are discarded and the count stops at BUF_LEN. Such a frame gets status bit 0 (truncated).
- R5: An error flag on any byte of a frame sets status bit 1. A recorded count below MIN_LEN sets status bit 2. Status bits 5..3 are always zero, so a good frame reads status 0.
- R6: If a start byte arrives while the current descriptor is not empty, `busy_pulse` goes high for one cycle. The whole frame is dropped, and no descriptor and no ring position change.
- R7: A release on a non-empty descriptor sets empty, zeroes its count and status, and loads wrap from `host_wrap`. A release on an empty descriptor has no effect.
- R8: A start byte in the middle of a frame abandons the partial frame. Capture restarts at offset 0 of the same descriptor.
- R9: Bytes that arrive while no frame is open and that carry no start flag are ignored.
- R10: After reset, every descriptor is empty with count 0 and status 0. Only the last descriptor has wrap set, and `ring_pos` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A receive byte is present |
| rx_data | input | 8 | Receive byte |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_err | input | 1 | Line error on this byte |
| host_sel | input | IW | Descriptor index for the host port |
| host_byte | input | BW | Byte offset within the selected buffer |
| host_release | input | 1 | Return the selected descriptor to hardware |
| host_wrap | input | 1 | Wrap value loaded on release |
| host_empty | output | 1 | Selected descriptor empty flag |
| host_wrap_bit | output | 1 | Selected descriptor wrap flag |
| host_len | output | LW | Selected descriptor byte count |
| host_stat | output | 6 | Selected descriptor status (bit0 truncated, bit1 line error, bit2 runt) |
| host_data | output | 8 | Buffer byte at host_byte |
| ring_pos | output | IW | Descriptor the next frame will use |
| frame_done | output | 1 | One-cycle pulse when a descriptor is completed |
| busy_pulse | output | 1 | One-cycle pulse when a frame is dropped for lack of a descriptor |

## Verification
A wrong ring pointer shows up at `ring_pos` one cycle after the end byte. It also puts the next frame's count and data into the wrong descriptor, which the host port exposes right away. A faulty empty flag shows up either as a `busy_pulse` where none is expected, or as a completed descriptor being overwritten by a later frame. Both become visible at the end of the next frame. A wrong length counter or wrong accumulated error flags appear in the count and status of the very descriptor being filled, as soon as it is completed.

// File: rtl/rx_desc_ring.sv
module rx_desc_ring #(
  parameter int NDESC   = 2,
  parameter int BUF_LEN = 1520,
  parameter int MIN_LEN = 64,
  localparam int IW = (NDESC > 1) ? $clog2(NDESC) : 1,
  localparam int BW = (BUF_LEN > 1) ? $clog2(BUF_LEN) : 1,
  localparam int LW = $clog2(BUF_LEN + 1),
  localparam int AW = $clog2(NDESC * BUF_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_sof,
  input  logic          rx_eof,
  input  logic          rx_err,
  input  logic [IW-1:0] host_sel,
  input  logic [BW-1:0] host_byte,
  input  logic          host_release,
  input  logic          host_wrap,
  output logic          host_empty,
  output logic          host_wrap_bit,
  output logic [LW-1:0] host_len,
  output logic [5:0]    host_stat,
  output logic [7:0]    host_data,
  output logic [IW-1:0] ring_pos,
  output logic          frame_done,
  output logic          busy_pulse
);

  localparam logic [LW-1:0] FULL = LW'(BUF_LEN);
  localparam logic [LW-1:0] MINL = LW'(MIN_LEN);
  localparam logic [IW-1:0] LAST = IW'(NDESC - 1);

  logic [7:0]    mem [NDESC*BUF_LEN];
  logic          d_empty [NDESC];
  logic          d_wrap  [NDESC];
  logic [LW-1:0] d_len   [NDESC];
  logic [2:0]    d_stat  [NDESC];

  logic [IW-1:0] cur;
  logic          active;
  logic [LW-1:0] cnt;
  logic          err_acc, trunc_acc;

  logic [LW-1:0] pos, newcnt;
  logic          byte_in, over, finish, busy_c, err_n, trunc_n, runt_n;
  logic [IW-1:0] nxt;
  logic          rel_ok;

  assign pos     = rx_sof ? '0 : cnt;
  assign byte_in = rx_valid & (rx_sof ? d_empty[cur] : active);
  assign over    = byte_in & (pos == FULL);
  assign newcnt  = over ? pos : pos + 1'b1;
  assign err_n   = (~rx_sof & err_acc) | rx_err;
  assign trunc_n = (~rx_sof & trunc_acc) | over;
  assign runt_n  = newcnt < MINL;
  assign finish  = byte_in & rx_eof;
  assign busy_c  = rx_valid & rx_sof & ~d_empty[cur];
  assign nxt     = (d_wrap[cur] || cur == LAST) ? '0 : cur + 1'b1;
  assign rel_ok  = host_release & ~d_empty[host_sel];

  always_ff @(posedge clk) begin
    if (byte_in && !over)
      mem[AW'(cur) * AW'(BUF_LEN) + AW'(pos)] <= rx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur        <= '0;
      active     <= 1'b0;
      cnt        <= '0;
      err_acc    <= 1'b0;
      trunc_acc  <= 1'b0;
      frame_done <= 1'b0;
      busy_pulse <= 1'b0;
      for (int i = 0; i < NDESC; i++) begin
        d_empty[i] <= 1'b1;
        d_wrap[i]  <= (i == NDESC - 1);
        d_len[i]   <= '0;
        d_stat[i]  <= '0;
      end
    end else begin
      frame_done <= finish;
      busy_pulse <= busy_c;
      if (finish) begin
        active <= 1'b0;
        cur    <= nxt;
      end else if (byte_in) begin
        active    <= 1'b1;
        cnt       <= newcnt;
        err_acc   <= err_n;
        trunc_acc <= trunc_n;
      end else if (busy_c) begin
        active <= 1'b0;
      end
      for (int i = 0; i < NDESC; i++) begin
        if (finish && IW'(i) == cur) begin
          d_empty[i] <= 1'b0;
          d_len[i]   <= newcnt;
          d_stat[i]  <= {runt_n, err_n, trunc_n};
        end else if (rel_ok && IW'(i) == host_sel) begin
          d_empty[i] <= 1'b1;
          d_len[i]   <= '0;
          d_stat[i]  <= '0;
          d_wrap[i]  <= host_wrap;
        end
      end
    end
  end

  assign host_empty    = d_empty[host_sel];
  assign host_wrap_bit = d_wrap[host_sel];
  assign host_len      = d_len[host_sel];
  assign host_stat     = {3'b000, d_stat[host_sel]};
  assign host_data     = mem[AW'(host_sel) * AW'(BUF_LEN) + AW'(host_byte)];
  assign ring_pos      = cur;

  assert_owner_taken_R1: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !d_empty[$past(cur)] && frame_done);

  assert_ring_wraps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    finish && d_wrap[cur] |=> cur == '0);

  assert_len_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    host_len <= FULL);

  assert_busy_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_c |=> busy_pulse && $stable(cur) && !frame_done);

  assert_release_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rel_ok |=> d_empty[$past(host_sel)] && d_len[$past(host_sel)] == '0);

endmodule

// File: tb/rx_desc_ring_test.sv
module rx_desc_ring_test;
  localparam int ND = 4, BL = 16, ML = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, rx_valid, rx_sof, rx_eof, rx_err, host_release, host_wrap;
  logic [7:0] rx_data;
  logic [1:0] host_sel;
  logic [3:0] host_byte;
  logic host_empty, host_wrap_bit, frame_done, busy_pulse;
  logic [4:0] host_len;
  logic [5:0] host_stat;
  logic [7:0] host_data;
  logic [1:0] ring_pos;

  rx_desc_ring #(.NDESC(ND), .BUF_LEN(BL), .MIN_LEN(ML)) uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err),
    .host_sel(host_sel), .host_byte(host_byte), .host_release(host_release),
    .host_wrap(host_wrap), .host_empty(host_empty), .host_wrap_bit(host_wrap_bit),
    .host_len(host_len), .host_stat(host_stat), .host_data(host_data),
    .ring_pos(ring_pos), .frame_done(frame_done), .busy_pulse(busy_pulse));

  int total = 0, bad = 0;
  int exp_wrap [ND];
  int exp_cur;

  function automatic logic [7:0] pat(int s, int k);
    return 8'((s * 7 + k * 13 + 1) & 255);
  endfunction

  task automatic chk(int got, int exp, string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, got, exp);
    end
  endtask

  task automatic idle();
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = 0; rx_data = 0;
  endtask

  task automatic put(logic [7:0] d, logic s, logic e, logic r);
    rx_valid = 1; rx_data = d; rx_sof = s; rx_eof = e; rx_err = r;
    @(negedge clk);
  endtask

  task automatic frame(int len, int errk, int seed);
    for (int k = 0; k < len; k++)
      put(pat(seed, k), k == 0, k == len - 1, k == errk);
    idle();
  endtask

  task automatic release_d(int idx, int w);
    host_sel = 2'(idx); host_wrap = 1'(w); host_release = 1;
    @(negedge clk);
    host_release = 0;
    #1;
    chk(host_empty, 1, "R7 release sets empty");
    chk(host_len, 0, "R7 release zeroes count");
    chk(host_wrap_bit, w, "R7 release loads wrap");
    @(negedge clk);
  endtask

  task automatic check_desc(int idx, int len, int st, int seed, string tag);
    int n;
    n = (len > BL) ? BL : len;
    host_sel = 2'(idx); #1;
    chk(host_empty, 0, {tag, " R1 empty cleared"});
    chk(host_len, n, {tag, " R3 count"});
    chk(host_stat, st, {tag, " R5 status"});
    for (int k = 0; k < n; k++) begin
      host_byte = 4'(k); #1;
      chk(host_data, pat(seed, k), {tag, " R3 data byte"});
    end
    @(negedge clk);
  endtask

  function automatic int adv(int c);
    return (exp_wrap[c] != 0 || c == ND - 1) ? 0 : c + 1;
  endfunction

  function automatic int stat_of(int len, int err);
    int n;
    n = (len > BL) ? BL : len;
    return ((n < ML) ? 4 : 0) | (err ? 2 : 0) | ((len > BL) ? 1 : 0);
  endfunction

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    int idx, c0;
    idle(); host_sel = 0; host_byte = 0; host_release = 0; host_wrap = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < ND; i++) exp_wrap[i] = (i == ND - 1);
    exp_cur = 0;

    chk(ring_pos, 0, "R10 reset ring_pos");
    chk(frame_done, 0, "R10 reset frame_done");
    chk(busy_pulse, 0, "R10 reset busy");
    for (int i = 0; i < ND; i++) begin
      host_sel = 2'(i); #1;
      chk(host_empty, 1, "R10 reset empty");
      chk(host_len, 0, "R10 reset count");
      chk(host_stat, 0, "R10 reset status");
      chk(host_wrap_bit, exp_wrap[i], "R10 reset wrap");
    end
    @(negedge clk);

    for (int len = 1; len <= BL + 4; len++) begin
      idx = exp_cur;
      frame(len, -1, len);
      chk(frame_done, 1, "R1 frame_done pulse");
      exp_cur = adv(idx);
      chk(ring_pos, exp_cur, "R2 ring advance");
      check_desc(idx, len, stat_of(len, 0), len, "sweep R4");
      release_d(idx, exp_wrap[idx]);
    end

    idx = exp_cur;
    frame(10, 4, 77);
    exp_cur = adv(idx);
    check_desc(idx, 10, stat_of(10, 1), 77, "R5 line error");
    release_d(idx, exp_wrap[idx]);

    idx = exp_cur;
    for (int k = 0; k < 3; k++) put(pat(50, k), k == 0, 1'b0, 1'b0);
    frame(7, -1, 9);
    exp_cur = adv(idx);
    chk(ring_pos, exp_cur, "R8 restart one advance");
    check_desc(idx, 7, 0, 9, "R8 restart");
    release_d(idx, exp_wrap[idx]);

    for (int k = 0; k < 4; k++) put(pat(3, k), 1'b0, k == 3, 1'b0);
    idle(); #1;
    chk(frame_done, 0, "R9 stray bytes no frame");
    chk(ring_pos, exp_cur, "R9 stray bytes ring");
    host_sel = 2'(exp_cur); #1;
    chk(host_empty, 1, "R9 descriptor still empty");
    chk(host_len, 0, "R9 descriptor count untouched");
    @(negedge clk);

    c0 = exp_cur;
    for (int j = 0; j < ND; j++) begin
      frame(8, -1, 100 + j);
      exp_cur = adv(exp_cur);
      @(negedge clk);
    end
    chk(ring_pos, c0, "R2 full loop back");
    put(8'hAA, 1'b1, 1'b1, 1'b0);
    idle(); #1;
    chk(busy_pulse, 1, "R6 busy pulse");
    chk(frame_done, 0, "R6 no completion");
    chk(ring_pos, c0, "R6 ring unchanged");
    @(negedge clk);
    chk(busy_pulse, 0, "R6 busy one cycle");
    frame(5, -1, 200);
    chk(frame_done, 0, "R6 dropped frame not stored");
    check_desc(c0, 8, 0, 100, "R6 descriptor kept");
    release_d(c0, exp_wrap[c0]);
    host_sel = 2'(c0); host_release = 1; host_wrap = 1'(exp_wrap[c0] == 0);
    @(negedge clk);
    host_release = 0; #1;
    chk(host_wrap_bit, exp_wrap[c0], "R7 release of empty ignored");
    @(negedge clk);
    idx = c0;
    for (int j = 1; j < ND; j++) begin
      idx = adv(idx);
      release_d(idx, exp_wrap[idx]);
    end

    idx = exp_cur;
    frame(8, -1, 31);
    exp_cur = adv(idx);
    @(negedge clk);
    exp_wrap[idx] = 1;
    release_d(idx, 1);
    exp_cur = ring_pos;
    for (int j = 0; j < 2 * ND; j++) begin
      idx = exp_cur;
      frame(6, -1, 40 + j);
      exp_cur = adv(idx);
      chk(ring_pos, exp_cur, "R2 shortened ring advance");
      check_desc(idx, 6, 0, 40 + j, "R2 shortened ring");
      release_d(idx, exp_wrap[idx]);
    end

    summary();
  end
endmodule